// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block locates an Ethernet PHY on a shared management bus. It never drives the serial management lines itself. Instead it asks a separate management engine for register reads through a request/response interface. Before each request it waits for the engine's idle flag. It then waits for that flag again and takes the returned data. Every probe reads register 1, which is the PHY's basic status register.

A one-cycle start pulse begins discovery. When the preferred-address input is marked valid, that address is probed first. If the PHY answers with a believable status word, discovery ends there. If not, the preferred address is dropped and the scanner walks the whole address space from the highest address down to zero. It stops at the first PHY whose status word passes the check. The check rejects a word of all ones, which is what a floating bus returns. It also requires every bit of a capability mask to be set. Each wait on the engine has a cycle bound, and exceeding it aborts the run with a timeout.

The run ends with a one-cycle done pulse and exactly one of three outcomes: found with an address, not found, or timeout. The result stays unchanged until the next start.

Top module: `phy_addr_finder`

## Requirements
- R1: After reset, scan_done, phy_found, phy_absent, mgmt_timeout and mgmt_req are 0, and phy_addr is 0.
- R2: Every read request carries register number 1 on mgmt_reg.
- R3: A status word is accepted only when it differs from 16'hFFFF and has all bits of 16'h1808 set. A word that lacks any one of those bits, or that is all ones, is rejected.
- R4: With pref_valid = 1, when the preferred address answers with an accepted word, the run ends after exactly one request and reports that address.
- R5: With pref_valid = 1, when the preferred address is rejected, the scan starts over at address 31. The preferred address is probed again when it comes up in its turn.
- R6: The scan requests addresses in strictly descending order and stops at the first accepted address. The number of requests is 1 (for the preferred probe, if any) plus 32 minus the found address.
- R7: When no address is accepted, the run ends with phy_absent = 1 and phy_found = 0, after 32 scan requests.
- R8: mgmt_req is a single-cycle pulse and is raised only while mgmt_idle is 1.
- R9: If mgmt_idle stays low for POLL_LIMIT (20000) consecutive cycles while the scanner waits on it, the run ends with mgmt_timeout = 1. No further request is issued in that run.
- R10: scan_done is a one-cycle pulse with exactly one of phy_found, phy_absent, mgmt_timeout set. These flags and phy_addr stay unchanged until the next accepted start.
- R11: A start pulse that arrives while a run is in progress is ignored.
- R12: With pref_valid = 0, pref_addr has no effect and the first request goes to address 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins discovery |
| pref_valid | input | 1 | Preferred address present |
| pref_addr | input | 5 | Preferred PHY address to try first |
| mgmt_idle | input | 1 | Management engine ready / previous access complete |
| mgmt_rdata | input | 16 | Read data from the engine, valid when idle returns |
| mgmt_req | output | 1 | One-cycle read request to the engine |
| mgmt_phy | output | 5 | PHY address of the request |
| mgmt_reg | output | 5 | Register number of the request |
| scan_done | output | 1 | One-cycle pulse at the end of discovery |
| phy_found | output | 1 | A PHY was located |
| phy_addr | output | 5 | Located PHY address |
| phy_absent | output | 1 | No address answered with an accepted word |
| mgmt_timeout | output | 1 | The engine stayed busy beyond the poll limit |

## Verification
The hardest states to reach from the ports are the timeout outcomes, because an engine that is working never keeps its idle flag low for 20000 cycles. The bench's engine model therefore has two fault switches. One holds idle low before the first request, which covers the pre-request wait. The other never completes an accepted request, which covers the post-request wait. A second difficult case is a start pulse that lands in the middle of a long scan. It is produced by pulsing start a few cycles into a run and checking that the request count and the result still match the first run. Random PHY maps with sparse valid entries drive the descending-order and first-match checks.

// File: rtl/phy_scan_pkg.sv
package phy_scan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PRE   = 2'd1,
      ST_ISSUE = 2'd2,
      ST_POST  = 2'd3
   } scan_state_e;

   typedef struct packed {
      logic found;
      logic absent;
      logic tmo;
   } scan_flags_t;

endpackage

// File: rtl/scan_wait_timer.sv
module scan_wait_timer #(
   parameter int LIMIT = 20000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run)
         cnt <= '0;
      else if (cnt != LAST)
         cnt <= cnt + 1'b1;
   end

   assign expire = run && (cnt == LAST);
endmodule

// File: rtl/scan_resp_judge.sv
module scan_resp_judge #(
   parameter int              DATA_W      = 16,
   parameter logic [DATA_W-1:0] CAP_MASK  = 16'h1808,
   parameter bit              REJECT_ONES = 1'b1
) (
   input  logic [DATA_W-1:0] data,
   output logic              ok
);
   logic mask_hit;
   assign mask_hit = ((data & CAP_MASK) == CAP_MASK);

   generate
      if (REJECT_ONES) begin : g_ones_check
         assign ok = mask_hit && (data != {DATA_W{1'b1}});
      end else begin : g_mask_only
         assign ok = mask_hit;
      end
   endgenerate
endmodule

// File: rtl/scan_addr_cursor.sv
module scan_addr_cursor #(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              use_pref,
   input  logic [ADDR_W-1:0] pref,
   input  logic              step,
   output logic [ADDR_W-1:0] cur,
   output logic              in_pref,
   output logic              at_floor
);
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= '0;
         in_pref <= 1'b0;
      end else if (load) begin
         cur     <= use_pref ? pref : TOP;
         in_pref <= use_pref;
      end else if (step) begin
         if (in_pref) begin
            cur     <= TOP;
            in_pref <= 1'b0;
         end else begin
            cur <= cur - 1'b1;
         end
      end
   end

   assign at_floor = !in_pref && (cur == '0);
endmodule

// File: rtl/phy_addr_finder.sv
module phy_addr_finder #(
   parameter int                ADDR_W      = 5,
   parameter int                REG_W       = 5,
   parameter int                DATA_W      = 16,
   parameter int                STATUS_REG  = 1,
   parameter logic [DATA_W-1:0] CAP_MASK    = 16'h1808,
   parameter bit                REJECT_ONES = 1'b1,
   parameter int                POLL_LIMIT  = 20000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              pref_valid,
   input  logic [ADDR_W-1:0] pref_addr,
   input  logic              mgmt_idle,
   input  logic [DATA_W-1:0] mgmt_rdata,
   output logic              mgmt_req,
   output logic [ADDR_W-1:0] mgmt_phy,
   output logic [REG_W-1:0]  mgmt_reg,
   output logic              scan_done,
   output logic              phy_found,
   output logic [ADDR_W-1:0] phy_addr,
   output logic              phy_absent,
   output logic              mgmt_timeout
);
   import phy_scan_pkg::*;

   generate
      if (POLL_LIMIT < 2) begin : g_bad_limit
         $error("POLL_LIMIT must be at least 2");
      end
      if (STATUS_REG >= (1 << REG_W)) begin : g_bad_reg
         $error("STATUS_REG does not fit in REG_W bits");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("ADDR_W and DATA_W must be positive");
      end
   endgenerate

   scan_state_e st, st_nx;
   scan_flags_t flags;

   logic              waiting, expire, resp_ok;
   logic              load, step, post_done;
   logic              fin_found, fin_absent, fin_tmo;
   logic              scan_busy;
   logic [ADDR_W-1:0] cur;
   logic              in_pref, at_floor;

   assign scan_busy = (st != ST_IDLE);
   assign waiting   = (st == ST_PRE) || (st == ST_POST);
   assign load      = (st == ST_IDLE) && start;
   assign post_done = (st == ST_POST) && mgmt_idle;

   assign fin_found  = post_done && resp_ok;
   assign fin_absent = post_done && !resp_ok && at_floor;
   assign fin_tmo    = expire;
   assign step       = post_done && !resp_ok && !at_floor;

   scan_wait_timer #(.LIMIT(POLL_LIMIT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (waiting && !mgmt_idle),
      .expire (expire)
   );

   scan_resp_judge #(
      .DATA_W      (DATA_W),
      .CAP_MASK    (CAP_MASK),
      .REJECT_ONES (REJECT_ONES)
   ) u_judge (
      .data (mgmt_rdata),
      .ok   (resp_ok)
   );

   scan_addr_cursor #(.ADDR_W(ADDR_W)) u_cursor (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .use_pref (pref_valid),
      .pref     (pref_addr),
      .step     (step),
      .cur      (cur),
      .in_pref  (in_pref),
      .at_floor (at_floor)
   );

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (load) st_nx = ST_PRE;
         ST_PRE: begin
            if (expire)         st_nx = ST_IDLE;
            else if (mgmt_idle) st_nx = ST_ISSUE;
         end
         ST_ISSUE: st_nx = ST_POST;
         ST_POST: begin
            if (expire)                     st_nx = ST_IDLE;
            else if (fin_found || fin_absent) st_nx = ST_IDLE;
            else if (step)                  st_nx = ST_PRE;
         end
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags     <= '0;
         phy_addr  <= '0;
         scan_done <= 1'b0;
      end else begin
         scan_done <= fin_found || fin_absent || fin_tmo;
         if (load) begin
            flags    <= '0;
            phy_addr <= '0;
         end else if (fin_found) begin
            flags.found <= 1'b1;
            phy_addr    <= cur;
         end else if (fin_absent) begin
            flags.absent <= 1'b1;
         end else if (fin_tmo) begin
            flags.tmo <= 1'b1;
         end
      end
   end

   assign mgmt_req     = (st == ST_ISSUE);
   assign mgmt_phy     = cur;
   assign mgmt_reg     = REG_W'(STATUS_REG);
   assign phy_found    = flags.found;
   assign phy_absent   = flags.absent;
   assign mgmt_timeout = flags.tmo;

endmodule

// File: rtl/phy_addr_finder_chk.sv
module phy_addr_finder_chk #(
   parameter int ADDR_W     = 5,
   parameter int POLL_LIMIT = 20000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mgmt_idle,
   input logic              mgmt_req,
   input logic              scan_busy,
   input logic              scan_done,
   input logic              phy_found,
   input logic [ADDR_W-1:0] phy_addr,
   input logic              phy_absent,
   input logic              mgmt_timeout
);
   localparam int CW = $clog2(POLL_LIMIT + 3);

   logic [CW-1:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         low_run <= '0;
      else if (!scan_busy || mgmt_idle)
         low_run <= '0;
      else if (low_run != CW'(POLL_LIMIT + 1))
         low_run <= low_run + 1'b1;
   end

   // R8: requests only toward an idle engine, one cycle wide
   assert_req_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_req |-> mgmt_idle);
   assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_req |=> !mgmt_req);

   // R10: one outcome per completion, results frozen while idle
   assert_done_one_outcome_R10: assert property (@(posedge clk) disable iff (!rst_n)
      scan_done |-> ($countones({phy_found, phy_absent, mgmt_timeout}) == 1));
   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!scan_busy && !start) |=> ($stable(phy_found) && $stable(phy_absent) &&
                                  $stable(mgmt_timeout) && $stable(phy_addr)));

   // R7: absent excludes found
   assert_absent_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      phy_absent |-> !phy_found);

   // R9: the wait on a busy engine is bounded
   assert_wait_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= CW'(POLL_LIMIT));

   // R11: no requests outside a run
   assert_req_in_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_req |-> scan_busy);

endmodule

bind phy_addr_finder phy_addr_finder_chk #(
   .ADDR_W     (ADDR_W),
   .POLL_LIMIT (POLL_LIMIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .mgmt_idle    (mgmt_idle),
   .mgmt_req     (mgmt_req),
   .scan_busy    (scan_busy),
   .scan_done    (scan_done),
   .phy_found    (phy_found),
   .phy_addr     (phy_addr),
   .phy_absent   (phy_absent),
   .mgmt_timeout (mgmt_timeout)
);

// File: tb/test_phy_addr_finder.sv
module test_phy_addr_finder;
   localparam int PL = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        pref_valid = 1'b0;
   logic [4:0]  pref_addr = '0;
   logic        mgmt_idle;
   logic [15:0] mgmt_rdata;
   logic        mgmt_req;
   logic [4:0]  mgmt_phy;
   logic [4:0]  mgmt_reg;
   logic        scan_done, phy_found, phy_absent, mgmt_timeout;
   logic [4:0]  phy_addr;

   always #5 clk = ~clk;

   phy_addr_finder i_phy_addr_finder (
      .clk(clk), .rst_n(rst_n), .start(start),
      .pref_valid(pref_valid), .pref_addr(pref_addr),
      .mgmt_idle(mgmt_idle), .mgmt_rdata(mgmt_rdata),
      .mgmt_req(mgmt_req), .mgmt_phy(mgmt_phy), .mgmt_reg(mgmt_reg),
      .scan_done(scan_done), .phy_found(phy_found), .phy_addr(phy_addr),
      .phy_absent(phy_absent), .mgmt_timeout(mgmt_timeout)
   );

   // ---------------- engine model ----------------
   logic [15:0] bank [32];
   logic        idle_r, busy_r;
   logic        force_low = 1'b0;
   logic        stuck = 1'b0;
   int          bcnt;
   logic [4:0]  cap;
   int          nreq;
   int          seq_log [4096];
   bit          bad_reg, bad_idle;

   assign mgmt_idle = idle_r && !force_low;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_r     <= 1'b1;
         busy_r     <= 1'b0;
         bcnt       <= 0;
         cap        <= '0;
         mgmt_rdata <= '0;
      end else if (mgmt_req) begin
         if (mgmt_reg != 5'd1) bad_reg  <= 1'b1;
         if (!mgmt_idle)       bad_idle <= 1'b1;
         if (nreq < 4096) seq_log[nreq] <= int'(mgmt_phy);
         nreq   <= nreq + 1;
         busy_r <= 1'b1;
         idle_r <= 1'b0;
         bcnt   <= $urandom_range(1, 4);
         cap    <= mgmt_phy;
      end else if (busy_r && !stuck) begin
         if (bcnt <= 1) begin
            busy_r     <= 1'b0;
            idle_r     <= 1'b1;
            mgmt_rdata <= bank[cap];
         end else begin
            bcnt <= bcnt - 1;
         end
      end
   end

   // ---------------- checking ----------------
   int n_chk = 0;
   int n_bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic bit v_ok(input logic [15:0] v);
      return (v != 16'hFFFF) && ((v & 16'h1808) == 16'h1808);
   endfunction

   function automatic int exp_addr(input bit dv, input int da);
      if (dv && v_ok(bank[da])) return da;
      for (int a = 31; a >= 0; a--)
         if (v_ok(bank[a])) return a;
      return -1;
   endfunction

   function automatic int exp_nreq(input bit dv, input int da);
      int e;
      int b;
      e = exp_addr(dv, da);
      if (dv && v_ok(bank[da])) return 1;
      b = dv ? 1 : 0;
      if (e < 0) return b + 32;
      return b + 32 - e;
   endfunction

   task automatic fill_random(input int pct);
      for (int a = 0; a < 32; a++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < pct)           bank[a] = 16'($urandom) | 16'h1808;
         else if (r < pct + 30) bank[a] = 16'hFFFF;
         else                   bank[a] = 16'($urandom) & ~16'h0800;
      end
   endtask

   task automatic fill_const(input logic [15:0] v);
      for (int a = 0; a < 32; a++) bank[a] = v;
   endtask

   task automatic wait_done(output int cyc);
      cyc = 0;
      while (!scan_done && cyc < PL + 300) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   task automatic pulse_start(input bit dv, input int da);
      @(negedge clk);
      pref_valid = dv;
      pref_addr  = 5'(da);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Full run with expected results from the bench model.
   task automatic run_case(input bit dv, input int da, input string tag);
      int cyc, base, e, en, k, ok_seq, a;
      base = nreq;
      e    = exp_addr(dv, da);
      en   = exp_nreq(dv, da);
      bad_reg = 0; bad_idle = 0;
      pulse_start(dv, da);
      wait_done(cyc);
      chk(scan_done == 1'b1, {tag, " R10 done pulse seen"}, int'(scan_done), 1);
      if (e >= 0) begin
         chk(phy_found == 1'b1 && phy_absent == 1'b0 && mgmt_timeout == 1'b0,
             {tag, " R6 found flag"}, int'(phy_found), 1);
         chk(int'(phy_addr) == e, {tag, " R6 found address"}, int'(phy_addr), e);
      end else begin
         chk(phy_absent == 1'b1 && phy_found == 1'b0 && mgmt_timeout == 1'b0,
             {tag, " R7 absent flag"}, int'(phy_absent), 1);
      end
      chk(nreq - base == en, {tag, " R6 request count"}, nreq - base, en);
      // order of probed addresses
      ok_seq = 1; k = base;
      if (dv) begin
         if (seq_log[k] != da) ok_seq = 0;
         k++;
      end
      a = 31;
      while (k < nreq && k < 4096) begin
         if (seq_log[k] != a) ok_seq = 0;
         a--; k++;
      end
      chk(ok_seq == 1, {tag, " R5 R12 probe order"}, ok_seq, 1);
      chk(!bad_reg, {tag, " R2 register number"}, int'(bad_reg), 0);
      chk(!bad_idle, {tag, " R8 request while busy"}, int'(bad_idle), 0);
      @(negedge clk);
      chk(scan_done == 1'b0, {tag, " R10 done one cycle"}, int'(scan_done), 0);
      // disturb inputs, results must hold
      pref_valid = ~pref_valid;
      pref_addr  = pref_addr + 5'd7;
      repeat (3) @(negedge clk);
      chk(phy_found == (e >= 0) && (e < 0 || int'(phy_addr) == e),
          {tag, " R10 result hold"}, int'(phy_addr), e);
   endtask

   initial begin
      int cyc, base;
      void'($urandom(32'd4711));
      nreq = 0; bad_reg = 0; bad_idle = 0;
      fill_const(16'hFFFF);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!scan_done && !phy_found && !phy_absent && !mgmt_timeout && !mgmt_req
          && phy_addr == 5'd0, "R1 reset outputs", int'(phy_found), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(!scan_done && !mgmt_req, "R1 quiet after reset", int'(mgmt_req), 0);

      // R4 preferred address accepted
      fill_const(16'hFFFF); bank[7] = 16'h7849;
      run_case(1, 7, "R4 pref ok");
      // R5 preferred rejected, scan finds 5
      fill_const(16'h0000); bank[5] = 16'h1808; bank[9] = 16'h1800;
      run_case(1, 9, "R5 pref bad");
      // R5 preferred rejected but it is the only valid address of the scan? (missing bit)
      fill_const(16'hFFFF); bank[20] = 16'h1008; bank[2] = 16'hF9FE;
      run_case(1, 20, "R5 pref missing bit");
      // R12 no preference: pref_addr ignored, scan finds 31
      fill_const(16'hFFFF); bank[31] = 16'h1808; bank[10] = 16'h1808;
      run_case(0, 10, "R12 no pref");
      // R3 all-ones rejected, exact mask accepted at address 0
      fill_const(16'hFFFF); bank[0] = 16'h1808;
      run_case(0, 0, "R3 floor");
      // R3 mask bits one at a time missing
      fill_const(16'h1800); bank[1] = 16'h0808; bank[2] = 16'h1008;
      run_case(1, 2, "R3 partial mask");
      // R7 nothing answers
      fill_const(16'hFFFF);
      run_case(0, 0, "R7 empty");
      run_case(1, 31, "R7 empty pref");

      // R11 start during a run is ignored
      fill_const(16'hFFFF); bank[3] = 16'h3A0C;
      base = nreq;
      pulse_start(0, 0);
      repeat (10) @(negedge clk);
      pulse_start(1, 31);
      wait_done(cyc);
      chk(phy_found && int'(phy_addr) == 3, "R11 result after ignored start", int'(phy_addr), 3);
      chk(nreq - base == 29, "R11 request count", nreq - base, 29);
      repeat (2) @(negedge clk);

      // random maps
      for (int t = 0; t < 40; t++) begin
         fill_random((t % 4 == 0) ? 0 : 6);
         run_case(1'($urandom_range(0, 1)), $urandom_range(0, 31), "RND R6");
      end

      // R9 engine busy before the first request
      force_low = 1'b1;
      base = nreq;
      pulse_start(0, 0);
      wait_done(cyc);
      chk(mgmt_timeout && !phy_found && !phy_absent, "R9 pre-request timeout", int'(mgmt_timeout), 1);
      chk(cyc >= PL - 3 && cyc <= PL + 5, "R9 timeout latency", cyc, PL);
      chk(nreq == base, "R9 no request", nreq - base, 0);
      force_low = 1'b0;
      repeat (3) @(negedge clk);

      // R9 engine never finishes an accepted request
      fill_const(16'hFFFF);
      stuck = 1'b1;
      base = nreq;
      pulse_start(1, 4);
      wait_done(cyc);
      chk(mgmt_timeout && !phy_found && !phy_absent, "R9 post-request timeout", int'(mgmt_timeout), 1);
      repeat (5) @(negedge clk);
      chk(nreq - base == 1, "R9 single request before timeout", nreq - base, 1);
      chk(mgmt_timeout == 1'b1, "R10 timeout held", int'(mgmt_timeout), 1);

      // reset clears the stuck engine and results
      rst_n = 1'b0; stuck = 1'b0;
      repeat (2) @(negedge clk);
      chk(!mgmt_timeout && !phy_found && phy_addr == 5'd0, "R1 second reset", int'(mgmt_timeout), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      fill_const(16'hFFFF); bank[12] = 16'h1809;
      run_case(1, 12, "R4 after reset");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule